// File: doc/BRIEF.md
# Asynchronous Parallel Register Bus Master

This block lets synchronous logic reach an external network offload controller whose register port is an unclocked, SRAM-style parallel bus. A client presents one request at a time: an 11-bit control address and 16 bits of write data. Bit 10 of the control address chooses the direction (1 = write, 0 = read). Bits 9:0 go out on the address pins. The block then drives the active-low chip-select, read and write strobes through a fixed sequence of setup, strobe and hold phases. During writes it drives the bidirectional data bus. It returns the read data together with a one-cycle done pulse.

The bus carries no clock, so every phase is timed by counting cycles of the local clock. The cycle counts come from nanosecond parameters and a clock-frequency parameter in MHz, rounded up to at least one cycle. At the default 100 MHz these give 1 setup cycle, 6 strobe cycles and 1 hold cycle. The block also owns the active-low reset of the peripheral. After a system reset it holds that line low for a set number of cycles, releases it, and waits a further set time before it accepts the first request. Every bus output comes from a flop, so the strobes cannot glitch.

Top module: `pbus_master`

## Requirements
- R1: While `rst` is high, and for `RST_LOW_CYC` (default 20) clock edges after it falls, `per_rst_n` is 0. It then goes to 1. `req_ready` stays 0 until `RST_WAIT_CYC` (default 30) further edges have passed, and is 1 from then on.
- R2: When no access is in progress, `bus_cs_n`, `bus_rd_n` and `bus_wr_n` are 1 and `rsp_done` is 0. This also holds during and immediately after a reset, even one that arrives in the middle of an access.
- R3: After a request is accepted (`req_valid` and `req_ready` both 1 at a clock edge), `bus_cs_n` is 0 for exactly SETUP+STROBE+HOLD cycles (8 at defaults). Throughout that time `bus_addr` equals `req_caddr[9:0]` and does not change.
- R4: A request with `req_caddr[10]` = 1 is a write. `bus_wr_n` is 0 for exactly the strobe count (6 at defaults) and `bus_rd_n` stays 1. `bus_data` carries `req_wdata` in every cycle in which `bus_cs_n` is 0.
- R5: A request with `req_caddr[10]` = 0 is a read. `bus_rd_n` is 0 for exactly the strobe count and `bus_wr_n` stays 1. The block does not drive `bus_data` during a read. `rsp_rdata` holds the value on `bus_data` in the last strobe cycle and is valid when `rsp_done` is 1.
- R6: The strobe falls only after the setup count (1 at defaults) of chip-select-low cycles. It rises the hold count (1 at defaults) of cycles before `bus_cs_n` rises.
- R7: `rsp_done` is a single-cycle pulse, one per access. It comes in the first cycle in which `bus_cs_n` is back at 1. `req_ready` is 0 from acceptance through the done cycle and returns to 1 in the next cycle. A request offered while `req_ready` is 0 is ignored.
- R8: `bus_rd_n` and `bus_wr_n` are never 0 together. Neither is 0 while `bus_cs_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock, nominally 100 MHz |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request in this cycle |
| req_caddr | input | 11 | Control address; bit 10 = 1 write, 0 read; bits 9:0 to pins |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle pulse at the end of each access |
| rsp_rdata | output | 16 | Data captured by the last read |
| per_rst_n | output | 1 | Active-low reset to the peripheral |
| bus_cs_n | output | 1 | Active-low chip select |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_addr | output | 10 | Register address |
| bus_data | inout | 16 | Bidirectional data bus |

## Verification
The assertions check the cycle-level bus rules on every cycle:
- the two strobes never overlap, and neither is low without chip select;
- the address is stable while chip select is low;
- a strobe only falls after chip select has been low;
- the data bus is driven under the write strobe and never under the read strobe;
- done is one cycle long and never coincides with ready;
- no request is accepted while the peripheral is still in reset.

Only the bench scenarios can show the following:
- the exact phase lengths and the point at which read data is sampled;
- that written data lands at the right address and reads back correctly;
- that a request offered while the block is busy leaves no trace on the bus or in the peripheral;
- the reset release timing;
- recovery from a reset that arrives mid-strobe.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    localparam int PB_ADDR_W = 10;
    localparam int PB_DATA_W = 16;
    localparam int PB_CADDR_W = PB_ADDR_W + 1;

    typedef enum logic [2:0] {
        PB_IDLE,
        PB_SETUP,
        PB_STROBE,
        PB_HOLD,
        PB_DONE
    } pb_state_t;

    typedef struct packed {
        logic                 is_write;
        logic [PB_ADDR_W-1:0] addr;
        logic [PB_DATA_W-1:0] wdata;
    } pb_req_t;

    // Round a time in ns up to whole clock cycles, never below one.
    function automatic int ns_to_cycles(input int mhz, input int ns);
        int c;
        c = (ns * mhz + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pbus_rst_seq.sv
module pbus_rst_seq #(
    parameter int LOW_CYC  = 20,
    parameter int WAIT_CYC = 30
) (
    input  logic clk,
    input  logic rst,
    output logic per_rst_n,
    output logic init_done
);
    localparam int MAXC = (LOW_CYC > WAIT_CYC) ? LOW_CYC : WAIT_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            per_rst_n <= 1'b0;
            init_done <= 1'b0;
            cnt       <= '0;
        end else if (!per_rst_n) begin
            if (cnt == CW'(LOW_CYC - 1)) begin
                per_rst_n <= 1'b1;
                cnt       <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else if (!init_done) begin
            if (cnt == CW'(WAIT_CYC - 1)) begin
                init_done <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
    import pbus_pkg::*;
#(
    parameter int SETUP_CYC  = 1,
    parameter int STROBE_CYC = 6,
    parameter int HOLD_CYC   = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic init_done,
    input  logic req_valid,
    input  logic req_is_write,
    output logic req_ready,
    output logic accept,
    output logic capture,
    output logic hold_end,
    output logic cs_n,
    output logic rd_n,
    output logic wr_n,
    output logic done
);
    localparam int CW = $clog2(max3(SETUP_CYC, STROBE_CYC, HOLD_CYC) + 1);

    pb_state_t     state;
    logic [CW-1:0] cnt;
    logic          wr_q;
    logic          last;

    assign last      = (cnt == '0);
    assign req_ready = init_done && (state == PB_IDLE);
    assign accept    = req_valid && req_ready;
    assign capture   = (state == PB_STROBE) && last && !wr_q;
    assign hold_end  = (state == PB_HOLD) && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PB_IDLE;
            cnt   <= '0;
            wr_q  <= 1'b0;
            cs_n  <= 1'b1;
            rd_n  <= 1'b1;
            wr_n  <= 1'b1;
            done  <= 1'b0;
        end else begin
            unique case (state)
                PB_IDLE: begin
                    if (accept) begin
                        state <= PB_SETUP;
                        cnt   <= CW'(SETUP_CYC - 1);
                        wr_q  <= req_is_write;
                        cs_n  <= 1'b0;
                    end
                end
                PB_SETUP: begin
                    if (last) begin
                        state <= PB_STROBE;
                        cnt   <= CW'(STROBE_CYC - 1);
                        rd_n  <= wr_q;
                        wr_n  <= !wr_q;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PB_STROBE: begin
                    if (last) begin
                        state <= PB_HOLD;
                        cnt   <= CW'(HOLD_CYC - 1);
                        rd_n  <= 1'b1;
                        wr_n  <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PB_HOLD: begin
                    if (last) begin
                        state <= PB_DONE;
                        cs_n  <= 1'b1;
                        done  <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PB_DONE: begin
                    state <= PB_IDLE;
                    done  <= 1'b0;
                end
                default: state <= PB_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pbus_datapath.sv
module pbus_datapath
    import pbus_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 accept,
    input  pb_req_t              req,
    input  logic                 capture,
    input  logic                 hold_end,
    input  logic [PB_DATA_W-1:0] bus_din,
    output logic [PB_ADDR_W-1:0] bus_addr,
    output logic [PB_DATA_W-1:0] bus_dout,
    output logic                 bus_oe,
    output logic [PB_DATA_W-1:0] rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_addr <= '0;
            bus_dout <= '0;
            bus_oe   <= 1'b0;
            rdata    <= '0;
        end else begin
            if (accept) begin
                bus_addr <= req.addr;
                bus_dout <= req.wdata;
                bus_oe   <= req.is_write;
            end else if (hold_end) begin
                bus_oe <= 1'b0;
            end
            if (capture) begin
                rdata <= bus_din;
            end
        end
    end

endmodule

// File: rtl/pbus_master.sv
module pbus_master
    import pbus_pkg::*;
#(
    parameter int CLK_MHZ      = 100,
    parameter int SETUP_NS     = 10,
    parameter int STROBE_NS    = 60,
    parameter int HOLD_NS      = 10,
    parameter int RST_LOW_CYC  = 20,
    parameter int RST_WAIT_CYC = 30
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [PB_CADDR_W-1:0] req_caddr,
    input  logic [PB_DATA_W-1:0]  req_wdata,
    output logic                  rsp_done,
    output logic [PB_DATA_W-1:0]  rsp_rdata,
    output logic                  per_rst_n,
    output logic                  bus_cs_n,
    output logic                  bus_rd_n,
    output logic                  bus_wr_n,
    output logic [PB_ADDR_W-1:0]  bus_addr,
    inout  wire  [PB_DATA_W-1:0]  bus_data
);
    localparam int SETUP_CYC  = ns_to_cycles(CLK_MHZ, SETUP_NS);
    localparam int STROBE_CYC = ns_to_cycles(CLK_MHZ, STROBE_NS);
    localparam int HOLD_CYC   = ns_to_cycles(CLK_MHZ, HOLD_NS);

    logic                 init_done;
    logic                 accept;
    logic                 capture;
    logic                 hold_end;
    logic                 bus_oe;
    logic [PB_DATA_W-1:0] bus_dout;
    pb_req_t              req;

    assign req.is_write = req_caddr[PB_ADDR_W];
    assign req.addr     = req_caddr[PB_ADDR_W-1:0];
    assign req.wdata    = req_wdata;

    assign bus_data = bus_oe ? bus_dout : {PB_DATA_W{1'bz}};

    pbus_rst_seq #(
        .LOW_CYC  (RST_LOW_CYC),
        .WAIT_CYC (RST_WAIT_CYC)
    ) u_rst (
        .clk       (clk),
        .rst       (rst),
        .per_rst_n (per_rst_n),
        .init_done (init_done)
    );

    pbus_seq #(
        .SETUP_CYC  (SETUP_CYC),
        .STROBE_CYC (STROBE_CYC),
        .HOLD_CYC   (HOLD_CYC)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .init_done    (init_done),
        .req_valid    (req_valid),
        .req_is_write (req.is_write),
        .req_ready    (req_ready),
        .accept       (accept),
        .capture      (capture),
        .hold_end     (hold_end),
        .cs_n         (bus_cs_n),
        .rd_n         (bus_rd_n),
        .wr_n         (bus_wr_n),
        .done         (rsp_done)
    );

    pbus_datapath u_dp (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .req      (req),
        .capture  (capture),
        .hold_end (hold_end),
        .bus_din  (bus_data),
        .bus_addr (bus_addr),
        .bus_dout (bus_dout),
        .bus_oe   (bus_oe),
        .rdata    (rsp_rdata)
    );

endmodule

// File: rtl/pbus_master_chk.sv
module pbus_master_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_ready,
    input logic       rsp_done,
    input logic       per_rst_n,
    input logic       bus_cs_n,
    input logic       bus_rd_n,
    input logic       bus_wr_n,
    input logic [9:0] bus_addr,
    input logic       bus_oe
);

    // R8
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(!bus_rd_n && !bus_wr_n));

    // R8
    strobe_needs_cs_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd_n || !bus_wr_n) |-> !bus_cs_n);

    // R3
    addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_cs_n && $past(!bus_cs_n)) |-> $stable(bus_addr));

    // R6
    strobe_after_setup_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(bus_rd_n) || $fell(bus_wr_n)) |-> $past(!bus_cs_n));

    // R4
    write_drives_bus_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_wr_n |-> bus_oe);

    // R5
    read_releases_bus_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd_n |-> !bus_oe);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    // R7
    done_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> (!req_ready && bus_cs_n));

    // R1
    no_accept_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
        !per_rst_n |-> (!req_ready && bus_cs_n));

endmodule

bind pbus_master pbus_master_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .per_rst_n (per_rst_n),
    .bus_cs_n  (bus_cs_n),
    .bus_rd_n  (bus_rd_n),
    .bus_wr_n  (bus_wr_n),
    .bus_addr  (bus_addr),
    .bus_oe    (bus_oe)
);

// File: tb/tb_pbus_master.sv
`timescale 1ns/1ps
module tb_pbus_master;
    localparam int L_CYC = 20;
    localparam int W_CYC = 30;
    localparam int S_CYC = 1;
    localparam int T_CYC = 6;
    localparam int H_CYC = 1;
    localparam int NVEC  = 11;

    // {write, addr[9:0], data}
    localparam logic [26:0] VECS [NVEC] = '{
        {1'b1, 10'h000, 16'hA5C3},
        {1'b1, 10'h3FF, 16'h5A3C},
        {1'b1, 10'h155, 16'hFFFF},
        {1'b1, 10'h2AA, 16'h0000},
        {1'b0, 10'h000, 16'h0000},
        {1'b0, 10'h3FF, 16'h0000},
        {1'b0, 10'h155, 16'h0000},
        {1'b0, 10'h2AA, 16'h0000},
        {1'b0, 10'h0F0, 16'h0000},
        {1'b1, 10'h155, 16'h1234},
        {1'b0, 10'h155, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [10:0] req_caddr = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic        per_rst_n;
    logic        bus_cs_n;
    logic        bus_rd_n;
    logic        bus_wr_n;
    logic [9:0]  bus_addr;
    wire  [15:0] bus_data;

    logic [15:0] mem     [1024];
    logic [15:0] exp_mem [1024];

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit ended  = 0;

    always #5 clk = ~clk;

    pbus_master dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_caddr(req_caddr), .req_wdata(req_wdata), .rsp_done(rsp_done),
        .rsp_rdata(rsp_rdata), .per_rst_n(per_rst_n), .bus_cs_n(bus_cs_n),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_addr(bus_addr),
        .bus_data(bus_data)
    );

    // Peripheral model
    assign bus_data = (!bus_cs_n && !bus_rd_n) ? mem[bus_addr] : 16'bz;
    always @(posedge clk) begin
        if (!bus_cs_n && !bus_wr_n) mem[bus_addr] <= bus_data;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
            finish_run();
        end
    end

    // One access; spurious != 0 keeps offering another request while busy.
    task automatic access(input bit wr, input logic [9:0] a, input logic [15:0] d,
                          input bit spurious);
        int cs_n_cnt, str_cnt, oth_cnt, first_str, bad_addr, bad_data, busy_rdy;
        int done_at;
        logic [15:0] cap;
        cs_n_cnt = 0; str_cnt = 0; oth_cnt = 0; first_str = 0;
        bad_addr = 0; bad_data = 0; busy_rdy = 0; done_at = 0; cap = '0;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_caddr = {wr, a};
        req_wdata = d;
        @(negedge clk);
        if (spurious) begin
            req_caddr = {1'b1, 10'h022};
            req_wdata = 16'hDEAD;
        end else begin
            req_valid = 1'b0;
        end
        for (int i = 1; i <= 12; i++) begin
            if (rsp_done) begin
                done_at = i;
                req_valid = 1'b0;
                break;
            end
            if (req_ready) busy_rdy++;
            if (!bus_cs_n) begin
                cs_n_cnt++;
                if (bus_addr !== a) bad_addr++;
                if (wr && bus_data !== d) bad_data++;
            end
            if ((wr ? bus_wr_n : bus_rd_n) == 1'b0) begin
                str_cnt++;
                if (first_str == 0) first_str = i;
                if (!wr) cap = bus_data;
            end
            if ((wr ? bus_rd_n : bus_wr_n) == 1'b0) oth_cnt++;
            @(negedge clk);
        end
        check(cs_n_cnt == S_CYC + T_CYC + H_CYC, "R3 cs low cycles", cs_n_cnt, S_CYC + T_CYC + H_CYC);
        check(bad_addr == 0, "R3 address held", bad_addr, 0);
        check(str_cnt == T_CYC, wr ? "R4 write strobe width" : "R5 read strobe width", str_cnt, T_CYC);
        check(oth_cnt == 0, wr ? "R4 read strobe idle" : "R5 write strobe idle", oth_cnt, 0);
        check(first_str == S_CYC + 1, "R6 strobe after setup", first_str, S_CYC + 1);
        check(done_at == S_CYC + T_CYC + H_CYC + 1, "R7 done timing", done_at, S_CYC + T_CYC + H_CYC + 1);
        check(busy_rdy == 0, "R7 ready low while busy", busy_rdy, 0);
        check(bus_cs_n && bus_rd_n && bus_wr_n, "R7 bus idle at done", {bus_cs_n, bus_rd_n, bus_wr_n}, 3'b111);
        if (wr) begin
            check(bad_data == 0, "R4 data driven", bad_data, 0);
            check(mem[a] == d, "R4 data written", mem[a], d);
            exp_mem[a] = d;
        end else begin
            check(rsp_rdata == exp_mem[a], "R5 read data", rsp_rdata, exp_mem[a]);
            check(rsp_rdata == cap, "R5 sampled at last strobe", rsp_rdata, cap);
        end
        @(negedge clk);
        check(!rsp_done && req_ready, "R7 done one cycle, ready back", {rsp_done, req_ready}, 2'b01);
    endtask

    task automatic reset_and_check();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(bus_cs_n && bus_rd_n && bus_wr_n && !rsp_done, "R2 idle in reset",
              {bus_cs_n, bus_rd_n, bus_wr_n, rsp_done}, 4'b1110);
        check(!per_rst_n && !req_ready, "R1 held in reset", {per_rst_n, req_ready}, 2'b00);
        rst = 1'b0;
        for (int k = 1; k <= L_CYC + W_CYC; k++) begin
            @(negedge clk);
            if (k == L_CYC - 1) check(per_rst_n == 1'b0, "R1 per_rst_n low", per_rst_n, 0);
            if (k == L_CYC)     check(per_rst_n == 1'b1, "R1 per_rst_n released", per_rst_n, 1);
            if (k == L_CYC + W_CYC - 1) check(req_ready == 1'b0, "R1 ready waits", req_ready, 0);
            if (k == L_CYC + W_CYC)     check(req_ready == 1'b1, "R1 ready raised", req_ready, 1);
        end
        check(bus_cs_n && bus_rd_n && bus_wr_n && !rsp_done, "R2 idle after reset",
              {bus_cs_n, bus_rd_n, bus_wr_n, rsp_done}, 4'b1110);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin
            mem[i]     = 16'(i * 257) ^ 16'h5A5A;
            exp_mem[i] = 16'(i * 257) ^ 16'h5A5A;
        end
        @(negedge clk);
        reset_and_check();

        for (int v = 0; v < NVEC; v++) begin
            access(VECS[v][26], VECS[v][25:16], VECS[v][15:0], 1'b0);
        end

        // R7: request offered while busy is ignored
        access(1'b1, 10'h011, 16'h0F0F, 1'b1);
        begin
            int cs_seen;
            cs_seen = 0;
            repeat (20) begin
                @(negedge clk);
                if (!bus_cs_n) cs_seen++;
            end
            check(cs_seen == 0, "R7 busy request ignored (bus)", cs_seen, 0);
        end
        access(1'b0, 10'h022, 16'h0000, 1'b0);
        check(rsp_rdata == exp_mem[10'h022], "R7 busy request ignored (memory)", rsp_rdata, exp_mem[10'h022]);

        // R8: strobes never overlap, checked over a fresh read
        access(1'b0, 10'h011, 16'h0000, 1'b0);

        // R2: reset in the middle of a strobe
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_caddr = {1'b1, 10'h033};
        req_wdata = 16'hBEEF;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(!bus_wr_n, "R4 mid-access strobe low", bus_wr_n, 0);
        rst = 1'b1;
        @(negedge clk);
        check(bus_cs_n && bus_rd_n && bus_wr_n && !rsp_done, "R2 idle after mid-access reset",
              {bus_cs_n, bus_rd_n, bus_wr_n, rsp_done}, 4'b1110);
        exp_mem[10'h033] = mem[10'h033];
        reset_and_check();
        access(1'b0, 10'h3FF, 16'h0000, 1'b0);
        access(1'b1, 10'h200, 16'h8001, 1'b0);
        access(1'b0, 10'h200, 16'h0000, 1'b0);

        finish_run();
    end

endmodule